// File: doc/BRIEF.md
# Multi-Channel Expiry Timer Bank

This block is a bank of independent countdown timers behind a small register port. Each timer owns two 32-bit words: a reload word and a control word. Loading the reload word arms the counter with a new value. The control word enables the timer, selects periodic operation, triggers a reload on request and reports a sticky expiry flag. A timer counts down once per cycle in which the shared tick enable is high. It counts only while its own enable and the bank-wide run input are both high.

When a counter steps from 1 to 0, the timer raises a one-cycle pulse on its bit of `expire_pulse_o`. In one-shot mode it then stays at zero with its expiry flag set until software reloads it. In periodic mode it refills itself from the reload word on that same edge, so pulses keep arriving every reload-value ticks and the flag is never left set. The register port is single-cycle: writes take effect at the clock edge, and reads are combinational from the address.

Top module: `tmr_bank`

## Requirements
- R1: After a synchronous reset, every reload word, counter, enable, periodic bit and expiry flag is 0, and `expired_o`, `expire_pulse_o` and `rdata` are 0.
- R2: Timer n = 16*j + k sits at byte address j*0x1000 + k*0x100. A write to offset 0x0 stores the reload word and loads the counter with the written value. It also clears the expiry flag. The word reads back unchanged.
- R3: Offset 0x4 is the control word. Bit 0 is enable and bit 8 is periodic; both are read/write. Bit 1 is reload-on-write and always reads 0. Bit 2 is the expiry flag and is read-only. All other bits read 0, and writing them has no effect.
- R4: A timer's counter decrements once on each clock edge where `tick_en`, `mgr_en` and its enable are all 1 and its count is non-zero. Any write to that timer's registers in that cycle takes the place of the decrement. With a reload value V, the timer expires after exactly V counted ticks, whatever the gaps between those ticks.
- R5: When a one-shot counter steps from 1 to 0, its expiry flag is set and its `expire_pulse_o` bit is 1 for exactly one cycle.
- R6: The expiry flag stays at 1 until a reload word write or a control write with bit 1 set. Further ticks, clearing the enable, and control writes without bit 1 leave it at 1.
- R7: A control write with bit 1 set loads the counter from the stored reload word and clears the expiry flag. The timer then expires again after V counted ticks.
- R8: In periodic mode, on the edge where the counter leaves 1 it reloads from the reload word and pulses, and the expiry flag stays 0. Pulses then repeat every V counted ticks.
- R9: While `mgr_en` is 0 or the timer's enable is 0, its counter holds its value, and counting resumes from that value afterwards.
- R10: A timer whose counter is 0 does not count and does not pulse.
- R11: A read of an address that does not decode to an implemented timer's offset 0x0 or 0x4 returns 0, and a write to such an address changes no timer.
- R12: Bit n of `expired_o` equals timer n's expiry flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Shared tick enable for all counters |
| mgr_en | input | 1 | Bank-wide run enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (18) | Byte address of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| expired_o | output | NUM_TIMERS (8) | Per-timer sticky expiry flags |
| expire_pulse_o | output | NUM_TIMERS (8) | Per-timer one-cycle expiry pulses |

## Verification
On every cycle, the assertions check each counter's step: it holds when gated off, decrements by one when running, stays at zero, and loads on writes. They also check that expiry behaves differently in one-shot and periodic mode, that the sticky flag holds, and that unmapped reads return zero. Only the bench scenarios can show the end-to-end tick totals under irregular tick patterns. The same applies to the sweep across every timer's address, the masking of reserved bits on readback, and a reload after expiry restarting the full interval.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DATA_W   = 32;
    localparam int OFS_W    = 8;   // byte offset inside one timer slot
    localparam int K_W      = 4;   // timers per 4 KiB group (16)
    localparam int GRP_LSB  = OFS_W + K_W;

    localparam logic [OFS_W-1:0] OFS_RELOAD = 8'h00;
    localparam logic [OFS_W-1:0] OFS_CTRL   = 8'h04;

    localparam int B_EN     = 0;
    localparam int B_RELOAD = 1;
    localparam int B_EXP    = 2;
    localparam int B_PER    = 8;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_RELOAD,
        SEL_CTRL
    } reg_sel_e;

    typedef struct packed {
        logic periodic;
        logic enable;
    } ctrl_t;

    function automatic logic [DATA_W-1:0] pack_ctrl(ctrl_t c, logic expired);
        logic [DATA_W-1:0] w;
        w         = '0;
        w[B_EN]   = c.enable;
        w[B_EXP]  = expired;
        w[B_PER]  = c.periodic;
        return w;
    endfunction

    function automatic ctrl_t unpack_ctrl(logic [DATA_W-1:0] w);
        ctrl_t c;
        c.enable   = w[B_EN];
        c.periodic = w[B_PER];
        return c;
    endfunction

endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
    import tmr_pkg::*;
#(
    parameter int NUM_TIMERS = 8,
    parameter int ADDR_W     = 18,
    localparam int IDX_W     = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1,
    localparam int FLAT_W    = ADDR_W - OFS_W
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  wr_en,
    output reg_sel_e              sel,
    output logic [IDX_W-1:0]      idx,
    output logic [NUM_TIMERS-1:0] wr_reload,
    output logic [NUM_TIMERS-1:0] wr_ctrl
);

    // group j in the upper bits, slot k below it: {j,k} is j*16+k
    logic [FLAT_W-1:0] flat;
    logic              hit;

    assign flat = {addr[ADDR_W-1:GRP_LSB], addr[GRP_LSB-1:OFS_W]};
    assign hit  = flat < FLAT_W'(NUM_TIMERS);
    assign idx  = flat[IDX_W-1:0];

    always_comb begin
        sel = SEL_NONE;
        if (hit) begin
            if (addr[OFS_W-1:0] == OFS_RELOAD)    sel = SEL_RELOAD;
            else if (addr[OFS_W-1:0] == OFS_CTRL) sel = SEL_CTRL;
        end
    end

    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_strobe
        assign wr_reload[i] = wr_en && (sel == SEL_RELOAD) && (flat == FLAT_W'(i));
        assign wr_ctrl[i]   = wr_en && (sel == SEL_CTRL)   && (flat == FLAT_W'(i));
    end

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              mgr_en,
    input  logic              wr_reload,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] reload_q,
    output ctrl_t             ctrl_q,
    output logic              expired_q,
    output logic              pulse_q
);

    logic [DATA_W-1:0] cnt_q;
    logic              gate;
    logic              run;
    logic              any_wr;

    assign gate   = tick_en && mgr_en && ctrl_q.enable;
    assign run    = gate && (cnt_q != '0);
    assign any_wr = wr_reload || wr_ctrl;

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q  <= '0;
            cnt_q     <= '0;
            ctrl_q    <= '0;
            expired_q <= 1'b0;
            pulse_q   <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (wr_reload) begin
                reload_q  <= wdata;
                cnt_q     <= wdata;
                expired_q <= 1'b0;
            end else if (wr_ctrl) begin
                ctrl_q <= unpack_ctrl(wdata);
                if (wdata[B_RELOAD]) begin
                    cnt_q     <= reload_q;
                    expired_q <= 1'b0;
                end
            end else if (run) begin
                if (cnt_q == DATA_W'(1)) begin
                    pulse_q <= 1'b1;
                    if (ctrl_q.periodic) begin
                        cnt_q     <= reload_q;
                        expired_q <= 1'b0;
                    end else begin
                        cnt_q     <= '0;
                        expired_q <= 1'b1;
                    end
                end else begin
                    cnt_q <= cnt_q - DATA_W'(1);
                end
            end
        end
    end

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        wr_reload |=> (cnt_q == $past(wdata)) && (reload_q == $past(wdata)) && !expired_q);

    assert_step_R4: assert property (@(posedge clk) disable iff (rst)
        (!any_wr && gate && cnt_q > DATA_W'(1)) |=> (cnt_q == $past(cnt_q) - DATA_W'(1)) && !pulse_q);

    assert_oneshot_R5: assert property (@(posedge clk) disable iff (rst)
        (!any_wr && gate && cnt_q == DATA_W'(1) && !ctrl_q.periodic) |=> pulse_q && expired_q && (cnt_q == '0));

    assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (expired_q && !wr_reload && !(wr_ctrl && wdata[B_RELOAD])) |=> expired_q);

    assert_reload_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && !wr_reload && wdata[B_RELOAD]) |=> (cnt_q == $past(reload_q)) && !expired_q);

    assert_periodic_R8: assert property (@(posedge clk) disable iff (rst)
        (!any_wr && gate && cnt_q == DATA_W'(1) && ctrl_q.periodic) |=> pulse_q && !expired_q && (cnt_q == $past(reload_q)));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!any_wr && !gate) |=> (cnt_q == $past(cnt_q)) && !pulse_q);

    assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (!any_wr && cnt_q == '0) |=> (cnt_q == '0) && !pulse_q);

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int NUM_TIMERS = 8,
    parameter int ADDR_W     = 18
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick_en,
    input  logic                  mgr_en,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    output logic [NUM_TIMERS-1:0] expired_o,
    output logic [NUM_TIMERS-1:0] expire_pulse_o
);

    localparam int IDX_W = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1;

    reg_sel_e              sel;
    logic [IDX_W-1:0]      idx;
    logic [NUM_TIMERS-1:0] wr_reload;
    logic [NUM_TIMERS-1:0] wr_ctrl;
    logic [DATA_W-1:0]     reload_arr [NUM_TIMERS];
    ctrl_t                 ctrl_arr   [NUM_TIMERS];

    tmr_decode #(
        .NUM_TIMERS (NUM_TIMERS),
        .ADDR_W     (ADDR_W)
    ) u_decode (
        .addr      (addr),
        .wr_en     (wr_en),
        .sel       (sel),
        .idx       (idx),
        .wr_reload (wr_reload),
        .wr_ctrl   (wr_ctrl)
    );

    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_chan
        tmr_chan u_chan (
            .clk       (clk),
            .rst       (rst),
            .tick_en   (tick_en),
            .mgr_en    (mgr_en),
            .wr_reload (wr_reload[i]),
            .wr_ctrl   (wr_ctrl[i]),
            .wdata     (wdata),
            .reload_q  (reload_arr[i]),
            .ctrl_q    (ctrl_arr[i]),
            .expired_q (expired_o[i]),
            .pulse_q   (expire_pulse_o[i])
        );
    end

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_RELOAD: rdata = reload_arr[idx];
            SEL_CTRL:   rdata = pack_ctrl(ctrl_arr[idx], expired_o[idx]);
            default:    rdata = '0;
        endcase
    end

    assert_unmapped_R11: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_NONE) |-> (rdata == '0));

    assert_single_write_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_reload, wr_ctrl}));

endmodule

// File: tb/tb_tmr_bank.sv
module tb_tmr_bank;

    localparam int N  = 8;
    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick_en = 1'b0;
    logic          mgr_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [N-1:0]  expired_o;
    logic [N-1:0]  expire_pulse_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    tmr_bank #(.NUM_TIMERS(N), .ADDR_W(AW)) dut (
        .clk            (clk),
        .rst            (rst),
        .tick_en        (tick_en),
        .mgr_en         (mgr_en),
        .wr_en          (wr_en),
        .addr           (addr),
        .wdata          (wdata),
        .rdata          (rdata),
        .expired_o      (expired_o),
        .expire_pulse_o (expire_pulse_o)
    );

    function automatic logic [AW-1:0] ta(int n, int ofs);
        return AW'(((n / 16) * 32'h1000) + ((n % 16) * 32'h100) + ofs);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
        addr = '0;
    endtask

    // tick pattern: mode 0 every cycle, 1 every other, 2 every third
    function automatic logic pat(int c, int mode);
        return (c % (mode + 1)) == 0;
    endfunction

    // runs until timer n pulses; returns ticks applied and stray pulses
    task automatic run_to_pulse(int n, int mode, int maxc,
                                output int ticks, output bit got, output int stray);
        ticks = 0; got = 1'b0; stray = 0;
        for (int c = 0; c < maxc && !got; c++) begin
            tick_en = pat(c, mode);
            @(posedge clk);
            if (tick_en) ticks++;
            @(negedge clk);
            if (expire_pulse_o[n]) got = 1'b1;
            if ((expire_pulse_o & ~(N'(1) << n)) != '0) stray++;
        end
        tick_en = 1'b0;
    endtask

    task automatic tick_n(int cyc, logic te, int n, output int pulses);
        pulses = 0;
        for (int c = 0; c < cyc; c++) begin
            tick_en = te;
            @(posedge clk);
            @(negedge clk);
            if (expire_pulse_o[n]) pulses++;
        end
        tick_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int t, st, p;
        bit g;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 expired_o", 32'(expired_o), 32'h0);
        check("R1 pulse", 32'(expire_pulse_o), 32'h0);
        for (int n = 0; n < N; n++) begin
            rd(ta(n, 0), d); check("R1 reload word", d, 32'h0);
            rd(ta(n, 4), d); check("R1 ctrl word", d, 32'h0);
        end

        mgr_en = 1'b1;

        // sweep every timer: one-shot expiry, sticky flag, reload bit
        for (int n = 0; n < N; n++) begin
            int v    = n + 2;
            int mode = n % 3;
            wr(ta(n, 0), 32'(v));
            rd(ta(n, 0), d); check("R2 reload readback", d, 32'(v));
            wr(ta(n, 4), 32'h1);
            run_to_pulse(n, mode, 200, t, g, st);
            check("R5 pulse seen", 32'(g), 32'h1);
            check("R4 ticks to expiry", 32'(t), 32'(v));
            check("R4 other timers quiet", 32'(st), 32'h0);
            check("R12 expired vector", 32'(expired_o), 32'(N'(1) << n));
            rd(ta(n, 4), d); check("R3 ctrl shows flag", d, 32'h5);
            tick_n(3, 1'b1, n, p);
            check("R5 single-cycle pulse", 32'(p), 32'h0);
            check("R6 flag stays", 32'(expired_o[n]), 32'h1);
            wr(ta(n, 4), 32'h0);
            check("R6 disable keeps flag", 32'(expired_o[n]), 32'h1);
            rd(ta(n, 4), d); check("R3 flag read-only", d, 32'h4);
            wr(ta(n, 4), 32'h3);
            check("R7 reload clears flag", 32'(expired_o), 32'h0);
            run_to_pulse(n, mode, 200, t, g, st);
            check("R7 re-expiry ticks", 32'(t), 32'(v));
            check("R7 re-expiry pulse", 32'(g), 32'h1);
            wr(ta(n, 4), 32'h0);
            wr(ta(n, 0), 32'h0);
            check("R2 reload write clears flag", 32'(expired_o), 32'h0);
        end

        // R8: periodic mode on timer 2
        wr(ta(2, 0), 32'd3);
        wr(ta(2, 4), 32'h101);
        for (int k = 0; k < 3; k++) begin
            run_to_pulse(2, k % 2, 100, t, g, st);
            check("R8 period ticks", 32'(t), 32'd3);
            check("R8 pulse", 32'(g), 32'h1);
            check("R8 flag stays clear", 32'(expired_o), 32'h0);
        end
        rd(ta(2, 4), d); check("R8 ctrl readback", d, 32'h101);
        wr(ta(2, 4), 32'h0);
        wr(ta(2, 0), 32'h0);

        // R9: freeze by bank enable and by timer enable
        wr(ta(1, 0), 32'd4);
        wr(ta(1, 4), 32'h1);
        tick_n(2, 1'b1, 1, p);
        check("R4 partial count no pulse", 32'(p), 32'h0);
        mgr_en = 1'b0;
        tick_n(5, 1'b1, 1, p);
        check("R9 bank enable low holds", 32'(p), 32'h0);
        mgr_en = 1'b1;
        wr(ta(1, 4), 32'h0);
        tick_n(4, 1'b1, 1, p);
        check("R9 timer enable low holds", 32'(p), 32'h0);
        wr(ta(1, 4), 32'h1);
        run_to_pulse(1, 0, 100, t, g, st);
        check("R9 resumes from held count", 32'(t), 32'd2);
        wr(ta(1, 4), 32'h0);
        wr(ta(1, 0), 32'h0);

        // R10: zero count is idle
        wr(ta(3, 0), 32'h0);
        wr(ta(3, 4), 32'h1);
        tick_n(10, 1'b1, 3, p);
        check("R10 no pulse at zero", 32'(p), 32'h0);
        check("R10 no flag at zero", 32'(expired_o), 32'h0);
        wr(ta(3, 4), 32'h0);

        // R3: reserved bits and reload bit read as 0
        wr(ta(4, 4), 32'hFFFF_FFFF);
        rd(ta(4, 4), d); check("R3 reserved masked", d, 32'h101);
        wr(ta(4, 4), 32'h0);
        rd(ta(4, 4), d); check("R3 cleared", d, 32'h0);

        // R11: unmapped addresses
        wr(ta(0, 0), 32'h55);
        wr(18'h00008, 32'h77);
        wr(18'h00800, 32'h99);
        wr(18'h01004, 32'h101);
        rd(18'h00008, d); check("R11 bad offset reads 0", d, 32'h0);
        rd(18'h00800, d); check("R11 timer 8 reads 0", d, 32'h0);
        rd(18'h01004, d); check("R11 group 1 reads 0", d, 32'h0);
        rd(ta(0, 0), d); check("R11 timer 0 untouched", d, 32'h55);
        for (int n = 1; n < N; n++) begin
            rd(ta(n, 0), d); check("R11 others untouched", d, 32'h0);
            rd(ta(n, 4), d); check("R11 ctrl untouched", d, 32'h0);
        end
        wr(ta(0, 0), 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule